// File: doc/BRIEF.md
# Serial Link Lock Sequencer

This controller walks one end of a serial transceiver from reset to a link that is ready for data. It holds everything idle until the clock-generation loop reports lock. It then watches the 2-bit phase decisions from the bit-alignment tracker and declares bit lock once the decisions have alternated between "up" and "down" for a programmed run. Next it enables the byte aligner, and when the aligner reports a frame boundary it declares byte lock.

While it is not byte locked, the transmitted control character is the "not locked" code. Once it is byte locked, the transmitter switches to the "locked" code. The link is reported ready when the local side is byte locked and the far end is seen sending the locked code. A decode error, or a relock request from a higher layer, drops byte lock and re-enables alignment. Losing clock-loop lock sends the sequencer back to the start.

Top module: `link_lock_seq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `bitLocked`, `alignEn`, `byteLocked`, `txSelLocked` and `linkUp` are all 0.
- R2: A low `dllLocked` sampled at a clock edge forces all five status outputs to 0 after that edge, whatever the other inputs are. While `dllLocked` stays low, no phase decision, alignment strobe or character class moves the sequencer.
- R3: `phaseDec` encoding: 2'b01 is up, 2'b10 is down, and 2'b00 or 2'b11 is ignore. Decisions are counted only after the edge at which `dllLocked` was first seen high. `bitLocked` rises one cycle after the edge that samples the RUN_LEN+1-th consecutive non-ignore decision, where each of those decisions differs from the one before it.
- R4: An ignore decision, or a non-ignore decision equal to the previous one, restarts the run. A run of only RUN_LEN alternating decisions does not give bit lock.
- R5: `alignEn` is 1 exactly while bit locked and not byte locked. `alignFound` has no effect at any other time.
- R6: `alignFound` sampled while `alignEn` is 1, with no relock cause in the same cycle, sets `byteLocked` and clears `alignEn` after that edge.
- R7: `txSelLocked` is 0 (send the not-locked code) until byte lock and 1 (send the locked code) while byte locked.
- R8: `decodeErr` or `relockReq` sampled while byte locked clears `byteLocked`, `txSelLocked` and `linkUp` and sets `alignEn` after that edge, with `bitLocked` staying 1. In the same cycle it overrides a locked-code class. During alignment it also overrides `alignFound`, so alignment continues.
- R9: `rxClass` encoding: 2'b10 is the locked code, 2'b01 is the not-locked code, and 2'b00 or 2'b11 is any other character. A locked-code class sampled while byte locked sets `linkUp` after that edge.
- R10: Once `linkUp` is 1, it stays 1 through other-character classes. A not-locked-code class drops it, and byte lock is kept.
- R11: `linkUp` is 1 only while `byteLocked` and `bitLocked` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dllLocked | input | 1 | Clock-generation loop is locked |
| phaseDec | input | 2 | Phase decision: 01 up, 10 down, 00/11 ignore |
| alignFound | input | 1 | Byte aligner found the frame offset |
| rxClass | input | 2 | Received character class: 10 locked code, 01 not-locked code, else other |
| decodeErr | input | 1 | Decoder saw an invalid character |
| relockReq | input | 1 | Higher layer requests byte realignment |
| bitLocked | output | 1 | Bit lock declared |
| alignEn | output | 1 | Byte aligner enable |
| byteLocked | output | 1 | Local byte lock |
| txSelLocked | output | 1 | Transmit control-character select: 1 locked code, 0 not-locked code |
| linkUp | output | 1 | Link ready for data |

## Verification
Two functions can fall in the same cycle here: acquiring a lock stage and abandoning byte lock. The bench raises `relockReq` in the same cycle as `alignFound` during alignment, and `decodeErr` in the same cycle as a locked-code class while waiting for the peer. In both cases it expects alignment to be enabled and byte lock to be absent after the edge. It also drops `dllLocked` together with a relock request while the link is up, and expects the sequencer to go back to the start rather than to realignment.

// File: rtl/link_lock_pkg.sv
package link_lock_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_DLL  = 3'd0,
    ST_BIT_ACQ   = 3'd1,
    ST_BYTE_ACQ  = 3'd2,
    ST_WAIT_PEER = 3'd3,
    ST_LINK_UP   = 3'd4
  } lockState_e;

  localparam logic [1:0] PH_UP       = 2'b01;
  localparam logic [1:0] PH_DN       = 2'b10;
  localparam logic [1:0] CLS_NOTLOCK = 2'b01;
  localparam logic [1:0] CLS_LOCKED  = 2'b10;

  // control -> datapath strobes
  typedef struct packed {
    logic runEn;      // count phase alternations
    logic peerWatch;  // decode far-end character class
  } ctrlStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic runDone;       // alternation run reached its target
    logic relock;        // decode error or relock request
    logic peerLocked;    // far end sends locked code
    logic peerUnlocked;  // far end sends not-locked code
  } linkEvt_t;

endpackage

// File: rtl/link_lock_dp.sv
module link_lock_dp
  import link_lock_pkg::*;
#(
  parameter int RUN_LEN = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [1:0]  phaseDec,
  input  logic [1:0]  rxClass,
  input  logic        decodeErr,
  input  logic        relockReq,
  output linkEvt_t    evt
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_TARGET = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] runCnt;
  logic [1:0]       prevDec;
  logic             prevValid;
  logic             isDecision;
  logic             isAlternate;

  assign isDecision  = (phaseDec == PH_UP) || (phaseDec == PH_DN);
  assign isAlternate = prevValid && (phaseDec != prevDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      prevDec   <= '0;
      prevValid <= 1'b0;
    end else if (!strb.runEn || !isDecision) begin
      runCnt    <= '0;
      prevValid <= 1'b0;
    end else begin
      prevDec   <= phaseDec;
      prevValid <= 1'b1;
      if (isAlternate)
        runCnt <= (runCnt == RUN_TARGET) ? runCnt : runCnt + 1'b1;
      else
        runCnt <= '0;
    end
  end

  always_comb begin
    evt.runDone      = strb.runEn && (runCnt == RUN_TARGET);
    evt.relock       = decodeErr || relockReq;
    evt.peerLocked   = strb.peerWatch && (rxClass == CLS_LOCKED);
    evt.peerUnlocked = strb.peerWatch && (rxClass == CLS_NOTLOCK);
  end

endmodule

// File: rtl/link_lock_ctrl.sv
module link_lock_ctrl
  import link_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dllLocked,
  input  logic        alignFound,
  input  linkEvt_t    evt,
  output ctrlStrobe_t strb,
  output lockState_e  state
);

  lockState_e nxtState;

  always_comb begin
    nxtState = state;
    case (state)
      ST_WAIT_DLL:  nxtState = ST_BIT_ACQ;
      ST_BIT_ACQ:   if (evt.runDone) nxtState = ST_BYTE_ACQ;
      ST_BYTE_ACQ:  if (!evt.relock && alignFound) nxtState = ST_WAIT_PEER;
      ST_WAIT_PEER: begin
        if (evt.relock)          nxtState = ST_BYTE_ACQ;
        else if (evt.peerLocked) nxtState = ST_LINK_UP;
      end
      ST_LINK_UP: begin
        if (evt.relock)            nxtState = ST_BYTE_ACQ;
        else if (evt.peerUnlocked) nxtState = ST_WAIT_PEER;
      end
      default:      nxtState = ST_WAIT_DLL;
    endcase
    if (!dllLocked) nxtState = ST_WAIT_DLL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT_DLL;
    else       state <= nxtState;
  end

  always_comb begin
    strb.runEn     = (state == ST_BIT_ACQ);
    strb.peerWatch = (state == ST_WAIT_PEER) || (state == ST_LINK_UP);
  end

endmodule

// File: rtl/link_lock_seq.sv
module link_lock_seq
  import link_lock_pkg::*;
#(
  parameter int RUN_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dllLocked,
  input  logic [1:0] phaseDec,
  input  logic       alignFound,
  input  logic [1:0] rxClass,
  input  logic       decodeErr,
  input  logic       relockReq,
  output logic       bitLocked,
  output logic       alignEn,
  output logic       byteLocked,
  output logic       txSelLocked,
  output logic       linkUp
);

  ctrlStrobe_t strb;
  linkEvt_t    evt;
  lockState_e  state;

  link_lock_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dllLocked  (dllLocked),
    .alignFound (alignFound),
    .evt        (evt),
    .strb       (strb),
    .state      (state)
  );

  link_lock_dp #(.RUN_LEN(RUN_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .phaseDec  (phaseDec),
    .rxClass   (rxClass),
    .decodeErr (decodeErr),
    .relockReq (relockReq),
    .evt       (evt)
  );

  always_comb begin
    bitLocked   = (state == ST_BYTE_ACQ) || (state == ST_WAIT_PEER) || (state == ST_LINK_UP);
    alignEn     = (state == ST_BYTE_ACQ);
    byteLocked  = (state == ST_WAIT_PEER) || (state == ST_LINK_UP);
    txSelLocked = byteLocked;
    linkUp      = (state == ST_LINK_UP);
  end

endmodule

// File: rtl/link_lock_chk.sv
module link_lock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dllLocked,
  input logic [1:0] phaseDec,
  input logic       alignFound,
  input logic [1:0] rxClass,
  input logic       decodeErr,
  input logic       relockReq,
  input logic       bitLocked,
  input logic       alignEn,
  input logic       byteLocked,
  input logic       txSelLocked,
  input logic       linkUp
);

  logic unusedIn;
  assign unusedIn = ^phaseDec;

  // R2
  dll_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dllLocked |=> !bitLocked && !alignEn && !byteLocked && !linkUp);

  // R5
  align_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignEn |-> bitLocked && !byteLocked);

  // R6
  align_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignEn && alignFound && dllLocked && !decodeErr && !relockReq |=> byteLocked && !alignEn);

  // R7
  tx_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    txSelLocked == byteLocked);

  // R8
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteLocked && dllLocked && (decodeErr || relockReq) |=> alignEn && bitLocked && !byteLocked && !linkUp);

  // R9
  peer_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteLocked && dllLocked && !decodeErr && !relockReq && rxClass == 2'b10 |=> linkUp);

  // R11
  up_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> byteLocked && bitLocked);

endmodule

bind link_lock_seq link_lock_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .dllLocked   (dllLocked),
  .phaseDec    (phaseDec),
  .alignFound  (alignFound),
  .rxClass     (rxClass),
  .decodeErr   (decodeErr),
  .relockReq   (relockReq),
  .bitLocked   (bitLocked),
  .alignEn     (alignEn),
  .byteLocked  (byteLocked),
  .txSelLocked (txSelLocked),
  .linkUp      (linkUp)
);

// File: tb/sim_link_lock_seq.sv
module sim_link_lock_seq;

  localparam int CLK_PERIOD = 10;
  localparam int RUN = 16;
  localparam logic [1:0] UP = 2'b01, DN = 2'b10, IG = 2'b00;
  localparam logic [1:0] C_OTH = 2'b00, C_NL = 2'b01, C_LK = 2'b10;

  // expected phase: 0 idle, 1 bit acq, 2 aligning, 3 wait peer, 4 link up
  typedef struct {
    int    ph;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nVec = 0;
  int nMis = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dllLocked = 1'b0;
  logic [1:0] phaseDec = IG;
  logic alignFound = 1'b0;
  logic [1:0] rxClass = C_OTH;
  logic decodeErr = 1'b0;
  logic relockReq = 1'b0;
  logic bitLocked, alignEn, byteLocked, txSelLocked, linkUp;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_lock_seq #(.RUN_LEN(RUN)) u0 (
    .clk(clk), .rstN(rstN), .dllLocked(dllLocked), .phaseDec(phaseDec),
    .alignFound(alignFound), .rxClass(rxClass), .decodeErr(decodeErr),
    .relockReq(relockReq), .bitLocked(bitLocked), .alignEn(alignEn),
    .byteLocked(byteLocked), .txSelLocked(txSelLocked), .linkUp(linkUp)
  );

  task automatic compare(input int ph, input string tag);
    logic [4:0] got, exp;
    got = {bitLocked, alignEn, byteLocked, txSelLocked, linkUp};
    exp = {ph >= 2, ph == 2, ph >= 3, ph >= 3, ph == 4};
    nVec++;
    if (got !== exp) begin
      nMis++;
      $display("FAIL %s: {bit,align,byte,tx,up} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // driver: apply one cycle of inputs, queue the expected status after the edge
  task automatic cyc(input logic dll, input logic [1:0] dec, input logic af,
                     input logic [1:0] cls, input logic err, input logic rq,
                     input int ph, input string tag);
    expItem_t it;
    @(negedge clk);
    dllLocked = dll; phaseDec = dec; alignFound = af;
    rxClass = cls; decodeErr = err; relockReq = rq;
    @(posedge clk);
    #(CLK_PERIOD/4);
    it.ph = ph; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      expItem_t it;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      compare(it.ph, it.tag);
    end
  end

  task automatic finish();
    wait (expQ.size() == 0);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nMis++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    compare(0, "R1 during reset");
    rstN = 1'b1;
    cyc(0, IG, 0, C_OTH, 0, 0, 0, "R1 after release");

    // R2 nothing moves without clock-loop lock
    for (int i = 0; i < 2 * RUN + 4; i++)
      cyc(0, (i % 2) ? DN : UP, 1, C_LK, 0, 0, 0, "R2 idle without dll");

    // enter bit acquisition; alignFound ignored there (R5)
    cyc(1, IG, 1, C_OTH, 0, 0, 1, "R3 enter bit acq");
    cyc(1, IG, 1, C_LK, 0, 0, 1, "R5 alignFound ignored in bit acq");

    // R4 a run of RUN alternating decisions is one short
    for (int i = 0; i < RUN; i++)
      cyc(1, (i % 2) ? DN : UP, 0, C_OTH, 0, 0, 1, "R4 short run");
    cyc(1, IG, 0, C_OTH, 0, 0, 1, "R4 short run no lock");
    cyc(1, IG, 0, C_OTH, 0, 0, 1, "R4 short run no lock");

    // R4 a repeated decision restarts the run
    for (int i = 0; i < 10; i++)
      cyc(1, (i % 2) ? DN : UP, 0, C_OTH, 0, 0, 1, "R4 pre-repeat");
    cyc(1, DN, 0, C_OTH, 0, 0, 1, "R4 repeat");
    for (int i = 0; i < RUN - 1; i++)
      cyc(1, (i % 2) ? DN : UP, 0, C_OTH, 0, 0, 1, "R4 post-repeat");
    cyc(1, IG, 0, C_OTH, 0, 0, 1, "R4 repeat no lock");

    // R3 exactly RUN+1 alternating decisions give bit lock one edge later
    for (int i = 0; i <= RUN; i++)
      cyc(1, (i % 2) ? DN : UP, 0, C_OTH, 0, 0, 1, "R3 run");
    cyc(1, IG, 0, C_OTH, 0, 0, 2, "R3 bit lock declared");

    // R5 aligning; R7 not-locked code still selected
    cyc(1, IG, 0, C_LK, 0, 0, 2, "R7 still not-locked code while aligning");
    cyc(1, IG, 0, C_OTH, 1, 0, 2, "R8 error while aligning keeps aligning");
    cyc(1, IG, 1, C_OTH, 0, 1, 2, "R8 relock overrides alignFound");
    cyc(1, IG, 1, C_OTH, 0, 0, 3, "R6 byte lock on alignFound");

    // waiting for peer
    cyc(1, IG, 0, C_NL, 0, 0, 3, "R9 peer not locked yet");
    cyc(1, IG, 1, C_OTH, 0, 0, 3, "R5 alignFound ignored when byte locked");
    cyc(1, IG, 0, C_LK, 1, 0, 2, "R8 error overrides locked class");
    cyc(1, IG, 1, C_OTH, 0, 0, 3, "R6 byte lock again");
    cyc(1, IG, 0, C_LK, 0, 0, 4, "R9 link up on locked class");

    // link up
    cyc(1, IG, 0, C_OTH, 0, 0, 4, "R10 data keeps link up");
    cyc(1, UP, 0, C_OTH, 0, 0, 4, "R10 data keeps link up");
    cyc(1, IG, 0, C_NL, 0, 0, 3, "R10 peer lost lock");
    cyc(1, IG, 0, C_LK, 0, 0, 4, "R9 link up again");
    cyc(1, IG, 0, C_LK, 0, 1, 2, "R8 relock from link up");
    cyc(1, IG, 1, C_OTH, 0, 0, 3, "R6 byte lock");
    cyc(1, IG, 0, C_LK, 0, 0, 4, "R11 link up");
    cyc(1, IG, 0, C_OTH, 1, 0, 2, "R8 decode error from link up");

    // R2 clock-loop drop from aligning, then restart counting
    cyc(0, UP, 1, C_LK, 0, 0, 0, "R2 dll drop while aligning");
    cyc(1, IG, 0, C_OTH, 0, 0, 1, "R2 back to bit acq");
    for (int i = 0; i <= RUN; i++)
      cyc(1, (i % 2) ? UP : DN, 0, C_OTH, 0, 0, 1, "R3 second run");
    cyc(1, IG, 0, C_OTH, 0, 0, 2, "R3 bit lock again");
    cyc(1, IG, 1, C_OTH, 0, 0, 3, "R6 byte lock");
    cyc(1, IG, 0, C_LK, 0, 0, 4, "R9 link up");
    cyc(0, IG, 0, C_LK, 0, 1, 0, "R2 dll drop beats relock");
    cyc(0, IG, 1, C_LK, 0, 0, 0, "R2 stays idle");

    finish();
  end

endmodule